// File: doc/BRIEF.md
# PWM Register Byte-Lane Write Front End

This block sits between an 8/16-bit processor bus and a PWM audio core. It owns the control word, the period (cycle) word and three pulse-width channels inside a sixteen-byte register window. Byte and word writes into that window are trimmed to the bits each register really has. Every write that completes a 16-bit value is turned into a single one-clock write strobe toward the core, carrying a word-aligned offset and the full word. The PWM counter, the sample queues and the audio outputs live in the core and are not part of this block.

A pulse channel can be loaded with one 16-bit write or with two byte writes. A byte write to the even (high) lane only parks that byte in a per-channel latch. The value goes to the core only when the odd (low) lane is written. That write takes the parked byte, or zero if none is parked, and then clears the latch. Either access style therefore yields exactly one push. Reads of the pulse registers return only a per-channel full flag supplied by the core.

The strobe output has no back-pressure. The core must accept one write per clock, and it alone decides whether to drop a pulse value pushed while its queue is full. Reads return data one cycle after the read request.

Top module: `pwm_wr_frontend`

## Requirements
- R1: After reset, `core_wr` and `rd_valid` are 0, `rd_data` is 0, and the control and cycle words read back as 0.
- R2: Writes to word offset 0x0 (control) keep only bits 3:0 of the high byte and mask 0x8f of the low byte. Unwritten lanes hold their value. Every such write forwards the full 16-bit control word (mask 0x0f8f) to the core at offset 0x0.
- R3: Writes to word offset 0x2 (cycle) keep only bits 3:0 of the high byte and all of the low byte. Every such write forwards the full cycle word at offset 0x2.
- R4: A high-lane-only write (`bus_be`=2'b10) to pulse offsets 0x4, 0x6 or 0x8 (channels 0, 1 and 2) latches the byte for that channel and produces no strobe.
- R5: A low-lane write (`bus_be`=2'b01) to a pulse channel forwards {latched high byte, written low byte} and then clears that channel's latch to 0. A second low-lane write therefore forwards a high byte of 0.
- R6: A word write (`bus_be`=2'b11) to a pulse channel forwards the whole word in one strobe and leaves other channels' latches untouched.
- R7: Writes to offsets 0xa through 0xf produce no strobe, and reads there return 0.
- R8: `core_wr` rises in the clock cycle after the accepted write and lasts exactly one clock per write. `core_addr` bit 0 is always 0, whatever `bus_addr` bit 0 is.
- R9: A pulse-register read returns `core_full[ch]` in bit 15 and 0 in bits 14:0. Pushes to a full channel are still forwarded.
- R10: `rd_valid` is high the cycle after `bus_rd`. At that point `rd_data` holds the addressed register (control or cycle word as stored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | 4 | Byte offset in the window; bit 0 ignored |
| bus_be | input | 2 | Lane enables: bit 1 high byte [15:8], bit 0 low byte [7:0] |
| bus_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| core_full | input | 3 | Per-channel pulse queue full flag from the core |
| core_wr | output | 1 | One-clock write strobe to the core |
| core_addr | output | 4 | Word-aligned offset of the forwarded write |
| core_wdata | output | 16 | Forwarded 16-bit word |

## Verification
The bench targets the split pulse write. If the latch were not cleared after a low-lane write, the next low-only write would carry a stale high byte. A design that pushed on the high lane would emit two strobes for one byte pair. Word writes on one channel are interleaved with a half-finished byte pair on another; a shared or wrongly indexed latch would corrupt the second channel's value. Control and cycle masks are checked with all-ones data, the reserved offsets are written and read to catch stray strobes, and the full flag is driven while pushing to show that no push is suppressed.

// File: rtl/pwm_fe_pkg.sv
package pwm_fe_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 16'h0f8f;
  localparam logic [DATA_W-1:0] CYCLE_KEEP = 16'h0fff;
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_CYCLE = 1;
  localparam int unsigned IDX_PULSE = 2;
endpackage

// File: rtl/pwm_fe_decode.sv
module pwm_fe_decode #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NCH    = 3
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  output logic              wr_ctrl,
  output logic              wr_cycle,
  output logic [NCH-1:0]    wr_hi,
  output logic [NCH-1:0]    wr_lo
);
  import pwm_fe_pkg::*;
  localparam int unsigned IW = ADDR_W - 1;

  logic [IW-1:0] widx;
  logic          unused_addr_lsb;

  assign widx            = bus_addr[ADDR_W-1:1];
  assign unused_addr_lsb = bus_addr[0];
  assign wr_ctrl  = bus_wr && (|bus_be) && (widx == IW'(IDX_CTRL));
  assign wr_cycle = bus_wr && (|bus_be) && (widx == IW'(IDX_CYCLE));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane_sel
    logic hit;
    assign hit       = bus_wr && (widx == IW'(IDX_PULSE + ch));
    assign wr_hi[ch] = hit && bus_be[1];
    assign wr_lo[ch] = hit && bus_be[0];
  end
endmodule

// File: rtl/pwm_fe_masked_reg.sv
module pwm_fe_masked_reg #(
  parameter int unsigned DW   = 16,
  parameter logic [DW-1:0] KEEP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    be,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q,
  output logic [DW-1:0] nxt
);
  localparam int unsigned HB = DW / 2;

  always_comb begin
    nxt = q;
    if (be[1]) nxt[DW-1:HB] = din[DW-1:HB] & KEEP[DW-1:HB];
    if (be[0]) nxt[HB-1:0]  = din[HB-1:0]  & KEEP[HB-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= nxt;
  end
endmodule

// File: rtl/pwm_fe_pulse_lane.sv
module pwm_fe_pulse_lane #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] din,
  output logic          push,
  output logic [DW-1:0] word
);
  localparam int unsigned HB = DW / 2;
  logic [HB-1:0] hi_q;

  assign push = wr_lo;
  assign word = {(wr_hi ? din[DW-1:HB] : hi_q), din[HB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_lo) hi_q <= '0;
    else if (wr_hi) hi_q <= din[DW-1:HB];
  end
endmodule

// File: rtl/pwm_wr_frontend.sv
module pwm_wr_frontend #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NCH    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  input  logic [NCH-1:0]    core_full,
  output logic              core_wr,
  output logic [ADDR_W-1:0] core_addr,
  output logic [15:0]       core_wdata
);
  import pwm_fe_pkg::*;
  localparam int unsigned IW = ADDR_W - 1;

  logic           wr_ctrl, wr_cycle;
  logic [NCH-1:0] wr_hi, wr_lo, lane_push;
  logic [15:0]    ctrl_q, ctrl_nxt, cycle_q, cycle_nxt;
  logic [15:0]    lane_word [NCH];

  pwm_fe_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .wr_ctrl(wr_ctrl), .wr_cycle(wr_cycle), .wr_hi(wr_hi), .wr_lo(wr_lo)
  );

  pwm_fe_masked_reg #(.DW(16), .KEEP(CTRL_KEEP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .be(bus_be), .din(bus_wdata),
    .q(ctrl_q), .nxt(ctrl_nxt)
  );

  pwm_fe_masked_reg #(.DW(16), .KEEP(CYCLE_KEEP)) u_cycle (
    .clk(clk), .rst_n(rst_n), .wr(wr_cycle), .be(bus_be), .din(bus_wdata),
    .q(cycle_q), .nxt(cycle_nxt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    pwm_fe_pulse_lane #(.DW(16)) u_lane (
      .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi[ch]), .wr_lo(wr_lo[ch]),
      .din(bus_wdata), .push(lane_push[ch]), .word(lane_word[ch])
    );
  end

  // Forward path: at most one source is active since one address is decoded.
  logic              fwd_wr;
  logic [ADDR_W-1:0] fwd_addr;
  logic [15:0]       fwd_data;

  always_comb begin
    fwd_wr   = 1'b0;
    fwd_addr = '0;
    fwd_data = '0;
    if (wr_ctrl) begin
      fwd_wr = 1'b1; fwd_addr = ADDR_W'(IDX_CTRL * 2); fwd_data = ctrl_nxt;
    end
    if (wr_cycle) begin
      fwd_wr = 1'b1; fwd_addr = ADDR_W'(IDX_CYCLE * 2); fwd_data = cycle_nxt;
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (lane_push[ch]) begin
        fwd_wr   = 1'b1;
        fwd_addr = ADDR_W'((IDX_PULSE + ch) * 2);
        fwd_data = lane_word[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_wr    <= 1'b0;
      core_addr  <= '0;
      core_wdata <= '0;
    end else begin
      core_wr <= fwd_wr;
      if (fwd_wr) begin
        core_addr  <= fwd_addr;
        core_wdata <= fwd_data;
      end
    end
  end

  // Read path
  logic [IW-1:0] rd_idx;
  logic [15:0]   rd_mux;
  assign rd_idx = bus_addr[ADDR_W-1:1];

  always_comb begin
    rd_mux = '0;
    if (rd_idx == IW'(IDX_CTRL))  rd_mux = ctrl_q;
    if (rd_idx == IW'(IDX_CYCLE)) rd_mux = cycle_q;
    for (int ch = 0; ch < NCH; ch++) begin
      if (rd_idx == IW'(IDX_PULSE + ch)) rd_mux = {core_full[ch], 15'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_rd;
      rd_data  <= bus_rd ? rd_mux : 16'h0000;
    end
  end
endmodule

// File: rtl/pwm_fe_checker.sv
module pwm_fe_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NCH    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_be,
  input logic              rd_valid,
  input logic [15:0]       rd_data,
  input logic              core_wr,
  input logic [ADDR_W-1:0] core_addr,
  input logic [15:0]       core_wdata
);
  localparam int unsigned IW = ADDR_W - 1;
  logic [IW-1:0] idx;
  assign idx = bus_addr[ADDR_W-1:1];

  p_addr_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |-> (core_addr[0] == 1'b0));

  p_strobe_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |-> $past(bus_wr));

  p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx >= IW'(2 + NCH)) |=> !core_wr);

  p_hi_only_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be == 2'b10 && idx >= IW'(2) && idx < IW'(2 + NCH)) |=> !core_wr);

  p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && core_addr == ADDR_W'(0)) |-> ((core_wdata & 16'hf070) == 16'h0000));

  p_cycle_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && core_addr == ADDR_W'(2)) |-> (core_wdata[15:12] == 4'h0));

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  p_pulse_status_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx >= IW'(2) && idx < IW'(2 + NCH)) |=> (rd_data[14:0] == 15'h0));
endmodule

bind pwm_wr_frontend pwm_fe_checker #(.ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_be(bus_be), .rd_valid(rd_valid), .rd_data(rd_data),
  .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata)
);

// File: tb/pwm_wr_frontend_bench.sv
module pwm_wr_frontend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [2:0]  core_full = '0;
  logic        core_wr;
  logic [3:0]  core_addr;
  logic [15:0] core_wdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_wr_frontend u_pwm_wr_frontend (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .core_full(core_full),
    .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write one cycle, then check the strobe and that it drops after one clock.
  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d,
                    input bit exp_wr, input logic [3:0] exp_a, input logic [15:0] exp_d,
                    input string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
    chk({tag, " strobe"}, {15'b0, core_wr}, {15'b0, exp_wr});
    if (exp_wr) begin
      chk({tag, " addr"}, {12'b0, core_addr}, {12'b0, exp_a});
      chk({tag, " data"}, core_wdata, exp_d);
    end
    @(negedge clk);
    chk({tag, " R8 one-clock strobe"}, {15'b0, core_wr}, 16'h0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk({tag, " rd_valid"}, {15'b0, rd_valid}, 16'h1);
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 core_wr after reset", {15'b0, core_wr}, 16'h0);
    chk("R1 rd_valid after reset", {15'b0, rd_valid}, 16'h0);
    chk("R1 rd_data after reset", rd_data, 16'h0);
    rd(4'h0, 16'h0000, "R1 ctrl reset value");
    rd(4'h2, 16'h0000, "R1 cycle reset value");
  endtask

  task automatic t_ctrl;
    wr(4'h0, 2'b11, 16'hffff, 1'b1, 4'h0, 16'h0f8f, "R2 ctrl word mask");
    wr(4'h0, 2'b10, 16'ha5ff, 1'b1, 4'h0, 16'h058f, "R2 ctrl high lane");
    wr(4'h1, 2'b01, 16'hff33, 1'b1, 4'h0, 16'h0503, "R2 ctrl low lane odd addr");
    rd(4'h0, 16'h0503, "R10 ctrl readback");
  endtask

  task automatic t_cycle;
    wr(4'h2, 2'b11, 16'hfedc, 1'b1, 4'h2, 16'h0edc, "R3 cycle word mask");
    wr(4'h3, 2'b01, 16'h0011, 1'b1, 4'h2, 16'h0e11, "R3 R8 cycle low lane addr bit0");
    wr(4'h2, 2'b10, 16'h7300, 1'b1, 4'h2, 16'h0311, "R3 cycle high lane");
    rd(4'h2, 16'h0311, "R10 cycle readback");
  endtask

  task automatic t_pulse_bytes;
    wr(4'h4, 2'b10, 16'h12ff, 1'b0, 4'h0, 16'h0, "R4 ch0 high only");
    wr(4'h5, 2'b01, 16'hff34, 1'b1, 4'h4, 16'h1234, "R5 ch0 merge");
    wr(4'h5, 2'b01, 16'hff56, 1'b1, 4'h4, 16'h0056, "R5 ch0 latch cleared");
  endtask

  task automatic t_pulse_word;
    wr(4'h6, 2'b10, 16'hab00, 1'b0, 4'h0, 16'h0, "R4 ch1 high only");
    wr(4'h8, 2'b11, 16'hbeef, 1'b1, 4'h8, 16'hbeef, "R6 ch2 word");
    wr(4'h4, 2'b11, 16'h1357, 1'b1, 4'h4, 16'h1357, "R6 ch0 word");
    wr(4'h7, 2'b01, 16'h00cd, 1'b1, 4'h6, 16'habcd, "R6 ch1 latch kept");
    wr(4'h9, 2'b01, 16'h0042, 1'b1, 4'h8, 16'h0042, "R6 ch2 no stale byte");
  endtask

  task automatic t_reserved;
    wr(4'ha, 2'b11, 16'hffff, 1'b0, 4'h0, 16'h0, "R7 write 0xa");
    wr(4'hd, 2'b01, 16'hffff, 1'b0, 4'h0, 16'h0, "R7 write 0xd");
    wr(4'he, 2'b10, 16'hffff, 1'b0, 4'h0, 16'h0, "R7 write 0xe");
    rd(4'hc, 16'h0000, "R7 read 0xc");
  endtask

  task automatic t_status;
    core_full = 3'b010;
    rd(4'h6, 16'h8000, "R9 ch1 full");
    rd(4'h4, 16'h0000, "R9 ch0 not full");
    wr(4'h6, 2'b11, 16'h2468, 1'b1, 4'h6, 16'h2468, "R9 push while full");
    core_full = 3'b101;
    rd(4'h9, 16'h8000, "R9 ch2 full");
    rd(4'h7, 16'h0000, "R9 ch1 cleared");
    core_full = 3'b000;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_cycle();
    t_pulse_bytes();
    t_pulse_word();
    t_reserved();
    t_status();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule